// File: doc/BRIEF.md
# Hysteresis Threshold Comparator Bank

This block is the digital model of a two-front-end sensor comparator stage. Each front-end serves four sensor inputs, which gives eight channels in all. Each channel owns a pair of 12-bit threshold registers. On a sample strobe the block receives a digitized sensor value and a channel index. It looks up the bit it last stored for that channel and uses it to pick one of the channel's two thresholds. It then does a strict greater-than comparison and stores the result, optionally inverted per front-end, back into the channel's bit of an 8-bit output vector. Because the stored bit picks the threshold, a channel can rise at one level and fall at a lower one, which gives hysteresis. The thresholds can be tuned per channel.

A sequencer outside the block drives the strobes and the per-sample comparator-on and reference-on controls. Software loads the thresholds through a simple write port. The second front-end has its own enable bits. The first front-end has a test override that replaces the hysteresis choice with the last two of its registers. A motion decoder downstream reads the output vector.

Top module: `hyst_cmp_bank`

## Requirements
- R1: A committed sample stores 1 when the sample value is strictly greater than the effective threshold, and 0 otherwise. Equality gives 0, before any inversion.
- R2: Bit 2 of `sample_ch` selects the front-end: 0 selects the first front-end, which owns output bits 0–3, and 1 selects the second, which owns bits 4–7. Bits 1:0 select the channel k within it, so the output bit is `sample_ch` itself. A sample changes no output bit other than that one.
- R3: Within a front-end, channel k reads threshold slot 2k when its stored bit is 0 and slot 2k+1 when its stored bit is 1.
- R4: `inv_fe1` flips the first front-end's comparison result before it is stored, and `inv_fe2` does the same for the second front-end. Neither affects the other front-end.
- R5: While `test_en` is 1, every first-front-end sample reads slot 6 when `test_sel` is 0 and slot 7 when it is 1. The second front-end always uses the R3 selection.
- R6: For the second front-end, the comparator is live only when `cmp_on` and `fe2_cmp_en` are both 1, and the reference is live only when `ref_on` and `fe2_ref_en` are both 1. With both enable bits at 0, its samples change nothing.
- R7: A cycle in which `sample_vld` is 0, or in which the addressed front-end's comparator is not live, leaves `out_bits` unchanged. When the reference is not live, the effective threshold is code 0.
- R8: A write with `wr_en` high stores `wr_data` into the register at `wr_addr`. Bit 3 of the address picks the front-end (0 = first) and bits 2:0 pick the slot. The write takes effect at the clock edge, so a sample in the same cycle still uses the old value. Reset clears all 16 registers and all 8 output bits.
- R9: A committed sample updates its output bit at the clock edge on which the strobe is seen. The new value can be read right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Threshold register write strobe |
| wr_addr | input | 4 | Write address: bit 3 = front-end, bits 2:0 = slot |
| wr_data | input | 12 | Threshold code to write |
| sample_vld | input | 1 | Sample strobe |
| sample_ch | input | 3 | Channel index; bit 2 = front-end |
| sample_val | input | 12 | Digitized sensor value |
| cmp_on | input | 1 | Sequencer comparator-on control for this sample |
| ref_on | input | 1 | Sequencer reference-on control for this sample |
| fe2_cmp_en | input | 1 | Second front-end comparator enable |
| fe2_ref_en | input | 1 | Second front-end reference enable |
| inv_fe1 | input | 1 | Invert first front-end result |
| inv_fe2 | input | 1 | Invert second front-end result |
| test_en | input | 1 | First front-end test override enable |
| test_sel | input | 1 | Test override slot select (0 = slot 6, 1 = slot 7) |
| out_bits | output | 8 | Stored comparator bits, one per channel |

## Verification
The bench builds the block with its default parameters: 12-bit codes and four channels per front-end. These are the values that give the 4-bit write address and the 3-bit channel index used above. They let the table-driven part walk both hysteresis slots of several channels on both front-ends with hand-picked values at, just above and just below each threshold. The directed part then covers inversion on each side, the test override, the second front-end's enable combinations, the reference-off zero threshold, a write that collides with a sample, and the exact edge on which a bit changes.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

  // Number of front-ends; the enable and test-override structure assumes two.
  localparam int FE_COUNT = 2;

  // Per-front-end control seen by the sample path.
  typedef struct packed {
    logic cmp_live;     // comparator may commit a result
    logic ref_live;     // threshold is driven; otherwise code 0
    logic invert;       // flip result before storing
    logic test_active;  // test override replaces hysteresis choice
  } fe_ctl_t;

endpackage

// File: rtl/hcb_ref_bank.sv
module hcb_ref_bank #(
  parameter int DATA_W = 12,
  parameter int SLOT_N = 8,
  parameter int FE_N   = 2,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int ADDR_W = SLOT_W + $clog2(FE_N),
  localparam int DEPTH  = FE_N * SLOT_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] thr_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        thr_q[i] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
        thr_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = thr_q[rd_addr];

endmodule

// File: rtl/hcb_fe_ctrl.sv
module hcb_fe_ctrl
  import hcb_pkg::*;
#(
  parameter int FE_N = 2
) (
  input  logic                 cmp_on,
  input  logic                 ref_on,
  input  logic                 fe2_cmp_en,
  input  logic                 fe2_ref_en,
  input  logic [FE_N-1:0]      inv,
  input  logic                 test_en,
  output fe_ctl_t [FE_N-1:0]   ctl
);

  for (genvar f = 0; f < FE_N; f++) begin : g_fe
    if (f == 0) begin : g_primary
      // First front-end: always follows the sequencer, owns the test override.
      assign ctl[f].cmp_live    = cmp_on;
      assign ctl[f].ref_live    = ref_on;
      assign ctl[f].test_active = test_en;
    end else begin : g_secondary
      // Further front-ends: sequencer controls gated by their own enables.
      assign ctl[f].cmp_live    = cmp_on & fe2_cmp_en;
      assign ctl[f].ref_live    = ref_on & fe2_ref_en;
      assign ctl[f].test_active = 1'b0;
    end
    assign ctl[f].invert = inv[f];
  end

endmodule

// File: rtl/hcb_out_reg.sv
module hcb_out_reg #(
  parameter int OUT_W = 8,
  localparam int IDX_W = $clog2(OUT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] idx,
  input  logic             bit_in,
  output logic [OUT_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (commit) begin
      q[idx] <= bit_in;
    end
  end

endmodule

// File: rtl/hyst_cmp_bank.sv
module hyst_cmp_bank
  import hcb_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CH_PER_FE = 4,
  localparam int FE_N   = FE_COUNT,
  localparam int OUT_W  = FE_N * CH_PER_FE,
  localparam int SLOT_N = 2 * CH_PER_FE,
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int LCH_W  = $clog2(CH_PER_FE),
  localparam int CH_W   = $clog2(OUT_W),
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sample_vld,
  input  logic [CH_W-1:0]   sample_ch,
  input  logic [DATA_W-1:0] sample_val,
  input  logic              cmp_on,
  input  logic              ref_on,
  input  logic              fe2_cmp_en,
  input  logic              fe2_ref_en,
  input  logic              inv_fe1,
  input  logic              inv_fe2,
  input  logic              test_en,
  input  logic              test_sel,
  output logic [OUT_W-1:0]  out_bits
);

  // Slot choice: hysteresis pair {channel, last bit}, or the top two slots in test.
  function automatic logic [SLOT_W-1:0] pick_slot(
    input logic [LCH_W-1:0] ch_local,
    input logic             last_bit,
    input logic             test_act,
    input logic             tsel
  );
    if (test_act) return SLOT_W'(SLOT_N - 2) | SLOT_W'(tsel);
    return {ch_local, last_bit};
  endfunction

  // Strict greater-than against the live threshold, then optional inversion.
  function automatic logic decide(
    input logic [DATA_W-1:0] val,
    input logic [DATA_W-1:0] thr,
    input logic              thr_live,
    input logic              inv
  );
    logic [DATA_W-1:0] eff;
    eff = thr_live ? thr : '0;
    return (val > eff) ^ inv;
  endfunction

  // Named internal events, exposed for the checker.
  logic                 fe_idx;
  logic [LCH_W-1:0]     ch_local;
  logic                 last_bit;
  fe_ctl_t [FE_N-1:0]   ctl;
  fe_ctl_t              cur;
  logic [SLOT_W-1:0]    sel_idx;
  logic [ADDR_W-1:0]    rd_addr;
  logic [DATA_W-1:0]    ref_level;
  logic                 fire;
  logic                 result_bit;

  assign fe_idx   = sample_ch[CH_W-1];
  assign ch_local = sample_ch[LCH_W-1:0];
  assign last_bit = out_bits[sample_ch];

  hcb_fe_ctrl #(.FE_N(FE_N)) ctrl_i (
    .cmp_on     (cmp_on),
    .ref_on     (ref_on),
    .fe2_cmp_en (fe2_cmp_en),
    .fe2_ref_en (fe2_ref_en),
    .inv        ({inv_fe2, inv_fe1}),
    .test_en    (test_en),
    .ctl        (ctl)
  );

  assign cur     = ctl[fe_idx];
  assign sel_idx = pick_slot(ch_local, last_bit, cur.test_active, test_sel);
  assign rd_addr = {fe_idx, sel_idx};

  hcb_ref_bank #(
    .DATA_W (DATA_W),
    .SLOT_N (SLOT_N),
    .FE_N   (FE_N)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (ref_level)
  );

  assign fire       = sample_vld & cur.cmp_live;
  assign result_bit = decide(sample_val, ref_level, cur.ref_live, cur.invert);

  hcb_out_reg #(.OUT_W(OUT_W)) out_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (fire),
    .idx    (sample_ch),
    .bit_in (result_bit),
    .q      (out_bits)
  );

endmodule

// File: rtl/hcb_checker.sv
module hcb_checker #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 8,
  parameter int CH_W   = 3,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_vld,
  input logic [CH_W-1:0]   sample_ch,
  input logic [DATA_W-1:0] sample_val,
  input logic              cmp_on,
  input logic              ref_on,
  input logic              fe2_cmp_en,
  input logic              fe2_ref_en,
  input logic              inv_fe1,
  input logic              test_en,
  input logic              test_sel,
  input logic [OUT_W-1:0]  out_bits,
  input logic              fire,
  input logic [SLOT_W-1:0] sel_idx,
  input logic [DATA_W-1:0] ref_level
);

  // R1: first front-end, reference live, no inversion -> stored bit is val > threshold
  p_cmp_strict_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sample_ch[CH_W-1] && !inv_fe1 && ref_on)
      |=> out_bits[$past(sample_ch)] == ($past(sample_val) > $past(ref_level)));

  // R2: a sample may change only its own bit
  p_only_own_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> ((out_bits ^ $past(out_bits)) & ~(OUT_W'(1) << $past(sample_ch))) == '0);

  // R2: at most one bit changes per cycle
  p_single_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> $countones(out_bits ^ $past(out_bits)) <= 1);

  // R3: second front-end slot comes from channel and its stored bit
  p_hyst_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && sample_ch[CH_W-1])
      |-> sel_idx == {sample_ch[CH_W-2:0], out_bits[sample_ch]});

  // R5: test override on the first front-end picks the top slot pair
  p_test_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && !sample_ch[CH_W-1] && test_en)
      |-> sel_idx == {{(SLOT_W-1){1'b1}}, test_sel});

  // R6: second front-end with both enables clear changes nothing
  p_fe2_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && sample_ch[CH_W-1] && !fe2_cmp_en && !fe2_ref_en)
      |=> $stable(out_bits));

  // R7: no strobe or comparator off -> outputs hold
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_vld && cmp_on) |=> $stable(out_bits));

endmodule

bind hyst_cmp_bank hcb_checker #(
  .DATA_W (DATA_W),
  .OUT_W  (OUT_W),
  .CH_W   (CH_W),
  .SLOT_W (SLOT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_vld (sample_vld),
  .sample_ch  (sample_ch),
  .sample_val (sample_val),
  .cmp_on     (cmp_on),
  .ref_on     (ref_on),
  .fe2_cmp_en (fe2_cmp_en),
  .fe2_ref_en (fe2_ref_en),
  .inv_fe1    (inv_fe1),
  .test_en    (test_en),
  .test_sel   (test_sel),
  .out_bits   (out_bits),
  .fire       (fire),
  .sel_idx    (sel_idx),
  .ref_level  (ref_level)
);

// File: tb/hyst_cmp_bank_tb_top.sv
`timescale 1ns/100ps
module hyst_cmp_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        sample_vld = 1'b0;
  logic [2:0]  sample_ch = '0;
  logic [11:0] sample_val = '0;
  logic        cmp_on = 1'b1;
  logic        ref_on = 1'b1;
  logic        fe2_cmp_en = 1'b1;
  logic        fe2_ref_en = 1'b1;
  logic        inv_fe1 = 1'b0;
  logic        inv_fe2 = 1'b0;
  logic        test_en = 1'b0;
  logic        test_sel = 1'b0;
  logic [7:0]  out_bits;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyst_cmp_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample_vld(sample_vld), .sample_ch(sample_ch), .sample_val(sample_val),
    .cmp_on(cmp_on), .ref_on(ref_on), .fe2_cmp_en(fe2_cmp_en), .fe2_ref_en(fe2_ref_en),
    .inv_fe1(inv_fe1), .inv_fe2(inv_fe2), .test_en(test_en), .test_sel(test_sel),
    .out_bits(out_bits)
  );

  // Table: {channel[2:0], value[11:0], expected stored bit}
  localparam logic [15:0] VEC [13] = '{
    {3'd0, 12'd100, 1'b0},  // equal to slot 0 -> 0
    {3'd0, 12'd101, 1'b1},  // above slot 0 -> 1
    {3'd0, 12'd60,  1'b1},  // bit 1 -> slot 1 (50): still high
    {3'd0, 12'd50,  1'b0},  // equal to slot 1 -> 0
    {3'd0, 12'd80,  1'b0},  // back on slot 0 (100): stays low
    {3'd1, 12'd201, 1'b1},  // slot 2 = 200
    {3'd1, 12'd151, 1'b1},  // slot 3 = 150
    {3'd1, 12'd150, 1'b0},
    {3'd4, 12'd301, 1'b1},  // second FE slot 0 = 300
    {3'd4, 12'd251, 1'b1},  // second FE slot 1 = 250
    {3'd4, 12'd249, 1'b0},
    {3'd2, 12'd1,   1'b1},  // slot 4 = 0
    {3'd2, 12'd0,   1'b0}   // slot 5 = 0
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic smp(input logic [2:0] ch, input logic [11:0] v);
    @(negedge clk);
    sample_vld = 1'b1; sample_ch = ch; sample_val = v;
    @(posedge clk); #1;
    sample_vld = 1'b0;
  endtask

  task automatic smp_bit(input string tag, input logic [2:0] ch, input logic [11:0] v,
                         input logic exp);
    smp(ch, v);
    chk(tag, {7'd0, out_bits[ch]}, {7'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset clears outputs", out_bits, 8'h00);
    rst_n = 1'b1;

    // Threshold load
    wr(4'd0, 12'd100);  wr(4'd1, 12'd50);
    wr(4'd2, 12'd200);  wr(4'd3, 12'd150);
    wr(4'd6, 12'd1000); wr(4'd7, 12'd900);
    wr(4'd8, 12'd300);  wr(4'd9, 12'd250);

    // R1 R3 table walk
    for (int i = 0; i < 13; i++) begin
      smp_bit($sformatf("R1/R3 vector %0d", i), VEC[i][15:13], VEC[i][12:1], VEC[i][0]);
    end
    chk("R2 table leaves other bits clear", out_bits, 8'h00);

    // R4 inversion, first front-end
    inv_fe1 = 1'b1;
    smp_bit("R4 inv1 high->0", 3'd0, 12'd101, 1'b0);
    smp_bit("R4 inv1 low->1",  3'd0, 12'd50,  1'b1);
    smp_bit("R4 inv1 slot1",   3'd0, 12'd50,  1'b1);
    smp_bit("R4 inv1 not on fe2", 3'd4, 12'd301, 1'b1);
    inv_fe1 = 1'b0;
    smp_bit("R4 fe2 back low", 3'd4, 12'd0, 1'b0);
    inv_fe2 = 1'b1;
    smp_bit("R4 inv2 low->1", 3'd4, 12'd0, 1'b1);
    inv_fe2 = 1'b0;
    smp_bit("R4 inv2 off", 3'd4, 12'd0, 1'b0);

    // R5 test override
    test_en = 1'b1; test_sel = 1'b0;
    smp_bit("R5 test slot6", 3'd0, 12'd950, 1'b0);
    test_sel = 1'b1;
    smp_bit("R5 test slot7", 3'd0, 12'd950, 1'b1);
    smp_bit("R5 fe2 ignores test", 3'd4, 12'd200, 1'b0);
    test_en = 1'b0; test_sel = 1'b0;

    // R7 hold and reference-off
    cmp_on = 1'b0;
    smp_bit("R7 cmp off holds", 3'd0, 12'd0, 1'b1);
    cmp_on = 1'b1;
    @(negedge clk);
    sample_ch = 3'd0; sample_val = 12'd0;
    @(posedge clk); #1;
    chk("R7 no strobe holds", out_bits, 8'h01);
    ref_on = 1'b0;
    smp_bit("R7 ref off -> zero threshold", 3'd1, 12'd5, 1'b1);
    ref_on = 1'b1;

    // R6 second front-end enables
    fe2_cmp_en = 1'b0; fe2_ref_en = 1'b0;
    smp_bit("R6 fe2 disabled", 3'd4, 12'd4000, 1'b0);
    fe2_ref_en = 1'b1;
    smp_bit("R6 fe2 cmp disabled", 3'd4, 12'd4000, 1'b0);
    fe2_cmp_en = 1'b1; fe2_ref_en = 1'b0;
    smp_bit("R6 fe2 ref disabled", 3'd4, 12'd5, 1'b1);
    fe2_ref_en = 1'b1;

    // R8 write port
    wr(4'd3, 12'd4000);
    smp_bit("R8 new slot3 used", 3'd1, 12'd3000, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd2; wr_data = 12'd4000;
    sample_vld = 1'b1; sample_ch = 3'd1; sample_val = 12'd300;
    @(posedge clk); #1;
    wr_en = 1'b0; sample_vld = 1'b0;
    chk("R8 same-cycle write uses old", {7'd0, out_bits[1]}, 8'd1);
    wr(4'd9, 12'd10);
    smp_bit("R8 fe2 address bit3", 3'd4, 12'd20, 1'b1);

    // R9 timing and R2 mapping
    @(negedge clk);
    sample_vld = 1'b1; sample_ch = 3'd5; sample_val = 12'd1;
    #2;
    chk("R9 not before edge", {7'd0, out_bits[5]}, 8'd0);
    @(posedge clk); #1;
    sample_vld = 1'b0;
    chk("R9 right after edge", {7'd0, out_bits[5]}, 8'd1);
    chk("R2 full vector", out_bits, 8'h33);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule